// File: doc/BRIEF.md
# Cursor and Blink Overlay Generator

This block sits in the display scan path, after the character pattern lookup. It takes the 5-dot pattern of the dot row being scanned and decides what actually reaches the display. That may be the pattern unchanged, all five dots lit (cursor underline or blink fill), or all dots dark (display disabled). It holds the blink phase timer, which counts oscillator ticks and flips between a "show character" half and a "fill cell" half.

The scan logic supplies the row index within the 8-row cell, a flag marking the cursor cell, and a flag that is high while the character generator RAM is being accessed. Software-visible enables for display, cursor and blink come from the control register elsewhere. Turning the cursor off changes only what is drawn. Address counting is handled outside and is not affected. The result is registered, so the output lags the inputs by one clock.

Top module: `cursor_blink_overlay`

## Requirements
- R1: While `rst_n` is low at a clock edge, `dots_out` becomes 5'b00000 and the blink phase returns to the character half, clearing the tick count.
- R2: With the cursor enabled, the row at index 7 of the cursor cell is drawn as 5'b11111, and the other rows of that cell show `char_dots`.
- R3: The blink phase starts in the character half. It flips after exactly `HALF_TICKS` oscillator ticks (default 75000, so a full period is 150000 ticks). It holds while `osc_tick` is low.
- R4: With blink enabled, every row of the cursor cell shows 5'b11111 during the fill half and `char_dots` during the character half.
- R5: When cursor and blink are enabled together, both apply. In the character half, row 7 is lit and the other rows show the character. In the fill half, all rows are lit.
- R6: While `cgram_access` is high, neither cursor nor blink modifies the output, and `char_dots` passes through.
- R7: Cells that are not the cursor cell always show `char_dots` unchanged.
- R8: While `disp_en` is low, the output is 5'b00000 whatever the cursor, blink and character state.
- R9: `dots_out` reflects the inputs sampled at the previous rising clock edge (one cycle of latency).
- R10: The blink timer runs whether or not blink is enabled. Enabling blink shows the phase already reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Synchronous reset, active low |
| osc_tick | input | 1 | One-cycle pulse per oscillator period |
| disp_en | input | 1 | Display enable |
| cursor_en | input | 1 | Cursor underline enable |
| blink_en | input | 1 | Blink enable |
| cgram_access | input | 1 | Character generator RAM access in progress |
| cell_is_cursor | input | 1 | Scanned cell is at the cursor position |
| dot_row | input | 3 | Row index within the 8-row cell |
| char_dots | input | 5 | Dot pattern of the scanned row |
| dots_out | output | 5 | Final dot pattern, registered |

## Verification
The bench targets the tick boundaries of the blink timer: one tick short of a half period, the exact flip point, and the return after a full period. A timer that is off by one would flip a tick early or late. It also checks that a reset in the middle of a count clears the partial count, which a design that only cleared the phase would fail. Further tests cover overlap of cursor and blink, suppression during RAM access, blanking with the display off, and a timer that keeps running while blink is disabled. A design that stalls the timer would show the wrong phase when blink is turned on. A design that forgets suppression would underline or fill while the RAM is being accessed.

// File: rtl/ovl_pkg.sv
// Package: shared types for the cursor/blink overlay.
// Assumes: the consumers pick their own widths through parameters.
package ovl_pkg;
    // Blink phase: show the character, or fill the whole cell.
    typedef enum logic {
        PH_CHAR = 1'b0,
        PH_FILL = 1'b1
    } blink_phase_e;

    // Decision made for one scanned row.
    typedef enum logic [1:0] {
        SEL_PASS  = 2'd0,
        SEL_FILL  = 2'd1,
        SEL_BLANK = 2'd2
    } row_sel_e;
endpackage

// File: rtl/ovl_blink_timer.sv
// Module: blink phase timer.
// Counts oscillator ticks and toggles the phase every HALF_TICKS ticks.
// Assumes: osc_tick is a one-cycle pulse synchronous to clk; reset is synchronous.
module ovl_blink_timer
    import ovl_pkg::*;
#(
    parameter int HALF_TICKS = 75000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         osc_tick,
    output blink_phase_e phase
);
    localparam int CNT_W = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_TICKS - 1);

    logic [CNT_W-1:0] cnt_q;
    blink_phase_e     phase_q;
    logic             wrap;

    // Purpose: detect the last tick of a half period.
    always_comb wrap = osc_tick && (cnt_q == LAST);

    // Purpose: advance the tick count and flip the phase on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            phase_q <= PH_CHAR;
        end else if (wrap) begin
            cnt_q   <= '0;
            phase_q <= (phase_q == PH_CHAR) ? PH_FILL : PH_CHAR;
        end else if (osc_tick) begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    assign phase = phase_q;

    // R3: the phase holds while no tick arrives.
    a_r3_phase_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_tick |=> $stable(phase_q));
    // R3: the count never runs past the half period.
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/ovl_row_compose.sv
// Module: decides the treatment of the scanned row.
// Fill means all dots lit (cursor row or blink fill half), blank means display off.
// Assumes: phase comes from ovl_blink_timer; the inputs are stable for the cycle.
module ovl_row_compose
    import ovl_pkg::*;
#(
    parameter int ROW_W      = 3,
    parameter int CURSOR_ROW = 7
) (
    input  logic             disp_en,
    input  logic             cursor_en,
    input  logic             blink_en,
    input  logic             cgram_access,
    input  logic             cell_is_cursor,
    input  logic [ROW_W-1:0] dot_row,
    input  blink_phase_e     phase,
    output row_sel_e         sel
);
    localparam logic [ROW_W-1:0] UL_ROW = ROW_W'(CURSOR_ROW);

    logic overlay_ok;
    logic cursor_hit;
    logic blink_hit;

    // Purpose: qualify the overlay and pick the row treatment.
    always_comb begin
        overlay_ok = cell_is_cursor && !cgram_access;
        cursor_hit = overlay_ok && cursor_en && (dot_row == UL_ROW);
        blink_hit  = overlay_ok && blink_en && (phase == PH_FILL);
        if (!disp_en)
            sel = SEL_BLANK;
        else if (cursor_hit || blink_hit)
            sel = SEL_FILL;
        else
            sel = SEL_PASS;
    end
endmodule

// File: rtl/ovl_dot_mux.sv
// Module: per-dot selector that applies the row treatment to each dot.
// Assumes: sel is one of the values of row_sel_e.
module ovl_dot_mux
    import ovl_pkg::*;
#(
    parameter int DOT_W = 5
) (
    input  row_sel_e         sel,
    input  logic [DOT_W-1:0] char_dots,
    output logic [DOT_W-1:0] dots
);
    for (genvar g = 0; g < DOT_W; g++) begin : g_dot
        // Purpose: choose this dot's level.
        always_comb begin
            unique case (sel)
                SEL_FILL:  dots[g] = 1'b1;
                SEL_BLANK: dots[g] = 1'b0;
                default:   dots[g] = char_dots[g];
            endcase
        end
    end
endmodule

// File: rtl/cursor_blink_overlay.sv
// Module: cursor and blink overlay generator (top).
// Combines the blink timer, the row decision and the dot mux, and registers the result.
// Assumes: synchronous active-low reset; inputs change only between clock edges.
module cursor_blink_overlay
    import ovl_pkg::*;
#(
    parameter int DOT_W      = 5,
    parameter int ROW_W      = 3,
    parameter int CURSOR_ROW = 7,
    parameter int HALF_TICKS = 75000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_tick,
    input  logic             disp_en,
    input  logic             cursor_en,
    input  logic             blink_en,
    input  logic             cgram_access,
    input  logic             cell_is_cursor,
    input  logic [ROW_W-1:0] dot_row,
    input  logic [DOT_W-1:0] char_dots,
    output logic [DOT_W-1:0] dots_out
);
    localparam logic [ROW_W-1:0] UL_ROW = ROW_W'(CURSOR_ROW);
    localparam logic [DOT_W-1:0] ALL_ON = '1;

    blink_phase_e     phase;
    row_sel_e         sel;
    logic [DOT_W-1:0] dots_d;
    logic [DOT_W-1:0] dots_q;

    ovl_blink_timer #(.HALF_TICKS(HALF_TICKS)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_tick (osc_tick),
        .phase    (phase)
    );

    ovl_row_compose #(.ROW_W(ROW_W), .CURSOR_ROW(CURSOR_ROW)) compose_i (
        .disp_en        (disp_en),
        .cursor_en      (cursor_en),
        .blink_en       (blink_en),
        .cgram_access   (cgram_access),
        .cell_is_cursor (cell_is_cursor),
        .dot_row        (dot_row),
        .phase          (phase),
        .sel            (sel)
    );

    ovl_dot_mux #(.DOT_W(DOT_W)) mux_i (
        .sel       (sel),
        .char_dots (char_dots),
        .dots      (dots_d)
    );

    // Purpose: register the final dot pattern.
    always_ff @(posedge clk) begin
        if (!rst_n) dots_q <= '0;
        else        dots_q <= dots_d;
    end

    assign dots_out = dots_q;

    // R8: display off gives a dark row on the next cycle.
    a_r8_dark: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_en |=> dots_q == '0);
    // R6: RAM access lets the character through untouched.
    a_r6_cgram_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_en && cgram_access) |=> dots_q == $past(char_dots));
    // R7: other cells are never modified.
    a_r7_plain_cell: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_en && !cell_is_cursor) |=> dots_q == $past(char_dots));
    // R2: underline row of the cursor cell is fully lit.
    a_r2_underline: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_en && cell_is_cursor && !cgram_access && cursor_en && dot_row == UL_ROW)
        |=> dots_q == ALL_ON);
endmodule

// File: tb/cursor_blink_overlay_tb_top.sv
`timescale 1ns/1ps
module cursor_blink_overlay_tb_top;
    localparam int HALF = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_tick = 1'b0;
    logic       disp_en = 1'b0;
    logic       cursor_en = 1'b0;
    logic       blink_en = 1'b0;
    logic       cgram_access = 1'b0;
    logic       cell_is_cursor = 1'b0;
    logic [2:0] dot_row = 3'd0;
    logic [4:0] char_dots = 5'd0;
    logic [4:0] dots_out;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cursor_blink_overlay #(.HALF_TICKS(HALF)) dut_i (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .disp_en(disp_en),
        .cursor_en(cursor_en), .blink_en(blink_en), .cgram_access(cgram_access),
        .cell_is_cursor(cell_is_cursor), .dot_row(dot_row),
        .char_dots(char_dots), .dots_out(dots_out)
    );

    task automatic check(input string req, input logic [4:0] exp);
        n_checks++;
        if (dots_out !== exp) begin
            n_fail++;
            $display("FAIL %s: dots_out=%b expected=%b", req, dots_out, exp);
        end
    endtask

    task automatic set_in(input logic de, input logic ce, input logic be,
                          input logic cg, input logic ac, input logic [2:0] row,
                          input logic [4:0] d);
        @(negedge clk);
        disp_en = de; cursor_en = ce; blink_en = be;
        cgram_access = cg; cell_is_cursor = ac; dot_row = row; char_dots = d;
    endtask

    task automatic step_check(input string req, input logic [4:0] exp);
        @(posedge clk); #1;
        check(req, exp);
    endtask

    task automatic pulse_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); osc_tick = 1'b1;
            @(negedge clk); osc_tick = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic test_reset();
        set_in(1, 1, 1, 0, 1, 3'd7, 5'b10101);
        rst_n = 1'b0;
        step_check("R1 reset dark", 5'b00000);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic test_passthrough();
        set_in(1, 1, 1, 0, 0, 3'd7, 5'b01101);
        step_check("R7 non-cursor row7", 5'b01101);
        set_in(1, 0, 0, 0, 0, 3'd2, 5'b10010);
        check("R9 output still old before edge", 5'b01101);
        step_check("R9 new value after one edge", 5'b10010);
    endtask

    task automatic test_cursor();
        set_in(1, 1, 0, 0, 1, 3'd7, 5'b00100);
        step_check("R2 underline row", 5'b11111);
        set_in(1, 1, 0, 0, 1, 3'd3, 5'b00100);
        step_check("R2 other row passes", 5'b00100);
    endtask

    task automatic test_blink();
        set_in(1, 0, 1, 0, 1, 3'd2, 5'b01010);
        step_check("R3 starts in character half", 5'b01010);
        pulse_ticks(HALF - 1);
        step_check("R3 one tick short no flip", 5'b01010);
        pulse_ticks(1);
        step_check("R4 fill half", 5'b11111);
        pulse_ticks(HALF - 1);
        step_check("R3 fill held one short", 5'b11111);
        pulse_ticks(1);
        step_check("R3 back after full period", 5'b01010);
        set_in(1, 0, 0, 0, 1, 3'd2, 5'b01010);
        pulse_ticks(HALF);
        step_check("R10 blink off shows char", 5'b01010);
        set_in(1, 0, 1, 0, 1, 3'd2, 5'b01010);
        step_check("R10 timer advanced while disabled", 5'b11111);
    endtask

    task automatic test_both();
        set_in(1, 1, 1, 0, 1, 3'd3, 5'b10001);
        step_check("R5 fill half row3", 5'b11111);
        pulse_ticks(HALF);
        step_check("R5 char half row3", 5'b10001);
        set_in(1, 1, 1, 0, 1, 3'd7, 5'b10001);
        step_check("R5 char half underline", 5'b11111);
    endtask

    task automatic test_cgram();
        set_in(1, 1, 1, 1, 1, 3'd7, 5'b00011);
        step_check("R6 underline suppressed", 5'b00011);
        pulse_ticks(HALF);
        set_in(1, 1, 1, 1, 1, 3'd1, 5'b11000);
        step_check("R6 blink suppressed", 5'b11000);
        set_in(1, 1, 1, 0, 1, 3'd1, 5'b11000);
        step_check("R4 fill after access ends", 5'b11111);
    endtask

    task automatic test_dark();
        set_in(0, 1, 1, 0, 1, 3'd7, 5'b10110);
        step_check("R8 cursor cell dark", 5'b00000);
        set_in(0, 0, 0, 0, 0, 3'd0, 5'b11111);
        step_check("R8 plain cell dark", 5'b00000);
    endtask

    task automatic test_reset_mid();
        pulse_ticks(HALF / 2);
        do_reset();
        set_in(1, 0, 1, 0, 1, 3'd4, 5'b00110);
        step_check("R1 phase cleared by reset", 5'b00110);
        pulse_ticks(HALF - 1);
        step_check("R1 partial count cleared", 5'b00110);
        pulse_ticks(1);
        step_check("R3 flip after full half", 5'b11111);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        test_reset();
        test_passthrough();
        test_cursor();
        test_blink();
        test_both();
        test_cgram();
        test_dark();
        test_reset_mid();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule